// File: doc/BRIEF.md
# Four-Port Power-Sourcing Mode Sequencer

This block holds one control state machine per port of a four-port power-sourcing controller. Each machine orders the steps for a powered device: it requests a detection measurement, then a classification measurement, then enables port power. Each port follows a two-bit operating mode. The analog front end runs the measurements and reports back through abstract flags: detection done and valid, classification done with a 3-bit class code, and an overcurrent shutdown event. The sequencer does not measure anything, limit current or drive a gate.

Software sets a mode register with one field per port. Software also supplies detect and classify enables, pushbutton pulses for manual work, and power-on and power-off pulses. A shared arbiter starts powering only one port at a time. A port with a busy fault timer is not started. Three timers are kept per port: a retry back-off for midspan installations, a restart hold-off after an overcurrent shutdown, and the turn-on window. Each port's state is visible on `st_code`. The codes are: 0 idle, 1 detecting, 2 back-off, 3 classifying, 4 waiting for power command, 5 requesting turn-on, 6 turning on, 7 powered, 8 restart hold-off. Transitions: idle→detecting or classifying (mode rules), detecting→classifying / waiting / idle / back-off, back-off→idle, classifying→requesting / waiting / idle, waiting→requesting, requesting→turning on (grant), turning on→powered, powered or turning on→hold-off or idle (overcurrent or power-off), hold-off→idle. Every state goes to idle when its port is put into shutdown.

Top module: `pse_port_sequencer`

## Requirements
- R1: The mode register `mode_q` holds port n's field at bits [2n+1:2n], with the encoding 00 shutdown, 01 manual, 10 semi-automatic, 11 automatic. While reset is held, every field takes 11 if `auto_pin` is high and 00 if it is low. A cycle with `mode_wr` high loads `mode_wdata` into the whole register.
- R2: In automatic mode a port raises `det_go` with no software input. A valid result leads to `cls_go` and then to power. An invalid result, with `midspan` low, brings `det_go` back one cycle after the result.
- R3: In semi-automatic mode, detection starts on `det_en`. Classification follows a valid result when `cls_en` is high. The port then waits with power off until a `pwr_on_cmd` pulse arrives.
- R4: When both enables are high, detection runs before classification. With `det_en` low and `cls_en` high, classification runs alone.
- R5: In manual mode a `det_push` or `cls_push` pulse starts exactly one operation. After the result the port goes idle with no further request.
- R6: A `pwr_on_cmd` pulse during detection or classification drops the measurement request on the next cycle. Power follows one cycle later. In automatic mode the pulse has no effect.
- R7: With `midspan` high, an invalid detection in automatic or semi-automatic mode keeps `det_go` low for RETRY_CYC+1 cycles after the result.
- R8: With `poff_bad_class` high, a class code of 111 never leads to power. In automatic mode the port returns to detection. In other modes `pwr_on_cmd` is ignored.
- R9: At most one port is in its TON_CYC-cycle turn-on window at any time, and the lowest-numbered requester is served first. A port whose `fault_busy` is high is not started.
- R10: An `ovc_fault` on a powered port removes power on the next cycle. With `rsrt_en` high, the next detection request waits RESTART_CYC+1 cycles instead of 1.
- R11: A port whose field reads 00 has `pwr_en`, `det_go` and `cls_go` low from the next cycle on.
- R12: `pwr_chg[n]` is high in exactly the first cycle in which `pwr_en[n]` differs from its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| auto_pin | input | 1 | Selects the reset value of every mode field |
| mode_wr | input | 1 | Load strobe for the mode register |
| mode_wdata | input | 2*NPORT | New mode register value |
| mode_q | output | 2*NPORT | Current mode register |
| det_en | input | NPORT | Detect enable (semi-automatic) |
| cls_en | input | NPORT | Classify enable (semi-automatic) |
| det_push | input | NPORT | Manual one-shot detection pulse |
| cls_push | input | NPORT | Manual one-shot classification pulse |
| pwr_on_cmd | input | NPORT | Software power-on pulse |
| pwr_off_cmd | input | NPORT | Software power-off pulse |
| midspan | input | 1 | Enables the back-off after a failed detection |
| poff_bad_class | input | 1 | Blocks power for class code 111 |
| rsrt_en | input | 1 | Enables the restart hold-off after overcurrent |
| det_done | input | NPORT | Front end: detection result valid this cycle |
| det_ok | input | NPORT | Front end: detected load is a valid device |
| cls_done | input | NPORT | Front end: class result valid this cycle |
| cls_in | input | 3*NPORT | Front end: class codes, port n at [3n+2:3n] |
| ovc_fault | input | NPORT | Front end: overcurrent shutdown event |
| fault_busy | input | NPORT | Fault timer of the port is nonzero |
| det_go | output | NPORT | Detection request |
| cls_go | output | NPORT | Classification request |
| pwr_en | output | NPORT | Port power enable |
| pwr_chg | output | NPORT | Power-enable change pulse |
| cls_code | output | 3*NPORT | Last class code per port |
| st_code | output | 4*NPORT | State code per port |

## Verification
The bench drives two ports to request power on the same edge. It checks that the second port's power rises TON_CYC+1 cycles after the first; an arbiter that ignored the turn-on window would power both together. It counts the exact dark cycles after a failed detection and after an overcurrent, with and without midspan or restart enable. An off-by-one counter load, or a timer applied in the wrong mode, shows as a wrong count. It sends power-on pulses in automatic mode, during detection and against a blocked class 111. A design that obeyed the pulse in the wrong place would power the port, and one that ignored it during measurement would keep requesting. It puts a powered port into shutdown and checks that power and requests drop within one cycle. It checks that manual pushbuttons run one step only and do not chain into classification.

// File: rtl/pse_seq_pkg.sv
package pse_seq_pkg;
    typedef enum logic [1:0] {
        MD_OFF  = 2'b00,
        MD_MAN  = 2'b01,
        MD_SEMI = 2'b10,
        MD_AUTO = 2'b11
    } pmode_e;

    typedef enum logic [3:0] {
        PS_IDLE    = 4'd0,
        PS_DET     = 4'd1,
        PS_BACKOFF = 4'd2,
        PS_CLS     = 4'd3,
        PS_WAIT    = 4'd4,
        PS_REQ     = 4'd5,
        PS_TURNON  = 4'd6,
        PS_ON      = 4'd7,
        PS_HOLD    = 4'd8
    } pstate_e;

    localparam int ST_W  = 4;
    localparam int CLS_W = 3;
endpackage

// File: rtl/pse_turnon_arb.sv
module pse_turnon_arb #(
    parameter int NPORT = 4
) (
    input  logic [NPORT-1:0] want,
    input  logic [NPORT-1:0] busy,
    output logic [NPORT-1:0] grant
);
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        if (busy == '0) begin
            for (int i = 0; i < NPORT; i++) begin
                if (want[i] && !found) begin
                    grant[i] = 1'b1;
                    found    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pse_port_fsm.sv
module pse_port_fsm
    import pse_seq_pkg::*;
#(
    parameter int RETRY_CYC   = 40,
    parameter int RESTART_CYC = 25,
    parameter int TON_CYC     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             det_en,
    input  logic             cls_en,
    input  logic             det_push,
    input  logic             cls_push,
    input  logic             pwr_on,
    input  logic             pwr_off,
    input  logic             midspan,
    input  logic             poff_bad,
    input  logic             rsrt_en,
    input  logic             det_done,
    input  logic             det_ok,
    input  logic             cls_done,
    input  logic [CLS_W-1:0] cls_in,
    input  logic             ovc,
    input  logic             grant,
    output logic             req_on,
    output logic             turning_on,
    output logic             det_go,
    output logic             cls_go,
    output logic             pwr_en,
    output logic             pwr_chg,
    output logic [CLS_W-1:0] cls_q,
    output logic [ST_W-1:0]  st
);
    localparam int MAX_AB = (RETRY_CYC > RESTART_CYC) ? RETRY_CYC : RESTART_CYC;
    localparam int MAXC   = (MAX_AB > TON_CYC) ? MAX_AB : TON_CYC;
    localparam int CNT_W  = $clog2(MAXC + 1);

    pmode_e md;
    pstate_e st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic pwr_q;
    logic blocked, on_ok, fault_to;

    assign md      = pmode_e'(mode);
    assign blocked = poff_bad && (cls_q == 3'b111);
    assign on_ok   = pwr_on && (md != MD_AUTO) && !blocked;

    // next state
    always_comb begin
        st_d     = st_q;
        cnt_d    = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
        fault_to = 1'b0;
        if (md == MD_OFF) begin
            st_d  = PS_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                PS_IDLE: begin
                    if (on_ok)                                 st_d = PS_REQ;
                    else if (md == MD_AUTO)                    st_d = PS_DET;
                    else if (md == MD_SEMI && det_en)          st_d = PS_DET;
                    else if (md == MD_SEMI && cls_en)          st_d = PS_CLS;
                    else if (md == MD_MAN && det_push)         st_d = PS_DET;
                    else if (md == MD_MAN && cls_push)         st_d = PS_CLS;
                end
                PS_DET: begin
                    if (on_ok) st_d = PS_REQ;
                    else if (det_done) begin
                        if (det_ok) begin
                            if (md == MD_MAN)                       st_d = PS_IDLE;
                            else if (md == MD_AUTO || cls_en)       st_d = PS_CLS;
                            else                                    st_d = PS_WAIT;
                        end else if (midspan && md != MD_MAN) begin
                            st_d  = PS_BACKOFF;
                            cnt_d = CNT_W'(RETRY_CYC - 1);
                        end else begin
                            st_d = PS_IDLE;
                        end
                    end
                end
                PS_BACKOFF: begin
                    if (on_ok)               st_d = PS_REQ;
                    else if (cnt_q == '0)    st_d = PS_IDLE;
                end
                PS_CLS: begin
                    if (on_ok) st_d = PS_REQ;
                    else if (cls_done) begin
                        if (md == MD_MAN)       st_d = PS_IDLE;
                        else if (md == MD_SEMI) st_d = PS_WAIT;
                        else st_d = (poff_bad && cls_in == 3'b111) ? PS_IDLE : PS_REQ;
                    end
                end
                PS_WAIT: begin
                    if (on_ok)              st_d = PS_REQ;
                    else if (md == MD_AUTO) st_d = PS_IDLE;
                end
                PS_REQ: begin
                    if (pwr_off)    st_d = PS_IDLE;
                    else if (grant) begin
                        st_d  = PS_TURNON;
                        cnt_d = CNT_W'(TON_CYC - 1);
                    end
                end
                PS_TURNON: begin
                    if (ovc)                fault_to = 1'b1;
                    else if (pwr_off)       st_d = PS_IDLE;
                    else if (cnt_q == '0)   st_d = PS_ON;
                end
                PS_ON: begin
                    if (ovc)          fault_to = 1'b1;
                    else if (pwr_off) st_d = PS_IDLE;
                end
                PS_HOLD: begin
                    if (cnt_q == '0) st_d = PS_IDLE;
                end
                default: st_d = PS_IDLE;
            endcase
            if (fault_to) begin
                if (rsrt_en) begin
                    st_d  = PS_HOLD;
                    cnt_d = CNT_W'(RESTART_CYC - 1);
                end else begin
                    st_d = PS_IDLE;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PS_IDLE;
            cnt_q <= '0;
            cls_q <= '0;
            pwr_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            pwr_q <= pwr_en;
            if (st_q == PS_CLS && cls_done && md != MD_OFF)
                cls_q <= cls_in;
        end
    end

    // outputs
    always_comb begin
        det_go     = (st_q == PS_DET);
        cls_go     = (st_q == PS_CLS);
        req_on     = (st_q == PS_REQ);
        turning_on = (st_q == PS_TURNON);
        pwr_en     = (st_q == PS_TURNON) || (st_q == PS_ON);
        pwr_chg    = pwr_en ^ pwr_q;
        st         = st_q;
    end
endmodule

// File: rtl/pse_port_sequencer.sv
module pse_port_sequencer
    import pse_seq_pkg::*;
#(
    parameter int NPORT       = 4,
    parameter int RETRY_CYC   = 40,
    parameter int RESTART_CYC = 25,
    parameter int TON_CYC     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   auto_pin,
    input  logic                   mode_wr,
    input  logic [2*NPORT-1:0]     mode_wdata,
    output logic [2*NPORT-1:0]     mode_q,
    input  logic [NPORT-1:0]       det_en,
    input  logic [NPORT-1:0]       cls_en,
    input  logic [NPORT-1:0]       det_push,
    input  logic [NPORT-1:0]       cls_push,
    input  logic [NPORT-1:0]       pwr_on_cmd,
    input  logic [NPORT-1:0]       pwr_off_cmd,
    input  logic                   midspan,
    input  logic                   poff_bad_class,
    input  logic                   rsrt_en,
    input  logic [NPORT-1:0]       det_done,
    input  logic [NPORT-1:0]       det_ok,
    input  logic [NPORT-1:0]       cls_done,
    input  logic [CLS_W*NPORT-1:0] cls_in,
    input  logic [NPORT-1:0]       ovc_fault,
    input  logic [NPORT-1:0]       fault_busy,
    output logic [NPORT-1:0]       det_go,
    output logic [NPORT-1:0]       cls_go,
    output logic [NPORT-1:0]       pwr_en,
    output logic [NPORT-1:0]       pwr_chg,
    output logic [CLS_W*NPORT-1:0] cls_code,
    output logic [ST_W*NPORT-1:0]  st_code
);
    logic [NPORT-1:0] req_on, turning_on, grant, want;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_q <= {NPORT{auto_pin ? MD_AUTO : MD_OFF}};
        else if (mode_wr) mode_q <= mode_wdata;
    end

    assign want = req_on & ~fault_busy;

    pse_turnon_arb #(.NPORT(NPORT)) u_arb (
        .want  (want),
        .busy  (turning_on),
        .grant (grant)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        pse_port_fsm #(
            .RETRY_CYC   (RETRY_CYC),
            .RESTART_CYC (RESTART_CYC),
            .TON_CYC     (TON_CYC)
        ) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode       (mode_q[2*p +: 2]),
            .det_en     (det_en[p]),
            .cls_en     (cls_en[p]),
            .det_push   (det_push[p]),
            .cls_push   (cls_push[p]),
            .pwr_on     (pwr_on_cmd[p]),
            .pwr_off    (pwr_off_cmd[p]),
            .midspan    (midspan),
            .poff_bad   (poff_bad_class),
            .rsrt_en    (rsrt_en),
            .det_done   (det_done[p]),
            .det_ok     (det_ok[p]),
            .cls_done   (cls_done[p]),
            .cls_in     (cls_in[CLS_W*p +: CLS_W]),
            .ovc        (ovc_fault[p]),
            .grant      (grant[p]),
            .req_on     (req_on[p]),
            .turning_on (turning_on[p]),
            .det_go     (det_go[p]),
            .cls_go     (cls_go[p]),
            .pwr_en     (pwr_en[p]),
            .pwr_chg    (pwr_chg[p]),
            .cls_q      (cls_code[CLS_W*p +: CLS_W]),
            .st         (st_code[ST_W*p +: ST_W])
        );
    end
endmodule

// File: rtl/pse_seq_chk.sv
module pse_seq_chk #(
    parameter int NPORT = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2*NPORT-1:0]   mode_q,
    input logic [NPORT-1:0]     pwr_en,
    input logic [NPORT-1:0]     pwr_chg,
    input logic [NPORT-1:0]     det_go,
    input logic [NPORT-1:0]     cls_go,
    input logic [NPORT-1:0]     fault_busy,
    input logic [4*NPORT-1:0]   st_code
);
    logic [NPORT-1:0] in_ton;

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        assign in_ton[p] = (st_code[4*p +: 4] == 4'd6);

        a_r11_shutdown_dark: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[2*p +: 2] == 2'b00) |=> (!pwr_en[p] && !det_go[p] && !cls_go[p]));

        a_r9_fault_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwr_en[p]) |-> !$past(fault_busy[p]));

        a_r9_start_from_request: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwr_en[p]) |-> ($past(st_code[4*p +: 4]) == 4'd5));

        a_r10_hold_dark: assert property (@(posedge clk) disable iff (!rst_n)
            (st_code[4*p +: 4] == 4'd8) |=> !pwr_en[p]);

        a_r12_change_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            pwr_chg[p] == (pwr_en[p] != $past(pwr_en[p])));

        a_r4_one_measure: assert property (@(posedge clk) disable iff (!rst_n)
            !(det_go[p] && cls_go[p]));
    end

    a_r9_single_turnon: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_ton) <= 1);
endmodule

bind pse_port_sequencer pse_seq_chk #(.NPORT(NPORT)) u_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (mode_q),
    .pwr_en     (pwr_en),
    .pwr_chg    (pwr_chg),
    .det_go     (det_go),
    .cls_go     (cls_go),
    .fault_busy (fault_busy),
    .st_code    (st_code)
);

// File: tb/test_pse_port_sequencer.sv
module test_pse_port_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NP   = 4;
    localparam int RTY  = 40;
    localparam int RST  = 25;
    localparam int TON  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_pin = 1'b0;
    logic mode_wr = 1'b0;
    logic [2*NP-1:0] mode_wdata = '0;
    logic [2*NP-1:0] mode_q;
    logic [NP-1:0] det_en = '0, cls_en = '0, det_push = '0, cls_push = '0;
    logic [NP-1:0] pwr_on_cmd = '0, pwr_off_cmd = '0;
    logic midspan = 1'b0, poff_bad_class = 1'b0, rsrt_en = 1'b0;
    logic [NP-1:0] det_done = '0, det_ok = '0, cls_done = '0;
    logic [3*NP-1:0] cls_in = '0;
    logic [NP-1:0] ovc_fault = '0, fault_busy = '0;
    logic [NP-1:0] det_go, cls_go, pwr_en, pwr_chg;
    logic [3*NP-1:0] cls_code;
    logic [4*NP-1:0] st_code;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pse_port_sequencer #(.NPORT(NP), .RETRY_CYC(RTY), .RESTART_CYC(RST), .TON_CYC(TON)) i_pse_port_sequencer (
        .clk(clk), .rst_n(rst_n), .auto_pin(auto_pin), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .mode_q(mode_q), .det_en(det_en), .cls_en(cls_en),
        .det_push(det_push), .cls_push(cls_push), .pwr_on_cmd(pwr_on_cmd),
        .pwr_off_cmd(pwr_off_cmd), .midspan(midspan), .poff_bad_class(poff_bad_class),
        .rsrt_en(rsrt_en), .det_done(det_done), .det_ok(det_ok), .cls_done(cls_done),
        .cls_in(cls_in), .ovc_fault(ovc_fault), .fault_busy(fault_busy),
        .det_go(det_go), .cls_go(cls_go), .pwr_en(pwr_en), .pwr_chg(pwr_chg),
        .cls_code(cls_code), .st_code(st_code)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic pin);
        rst_n = 1'b0;
        auto_pin = pin;
        det_en = '0; cls_en = '0; midspan = 1'b0; poff_bad_class = 1'b0; rsrt_en = 1'b0;
        fault_busy = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic set_mode(input logic [2*NP-1:0] v);
        mode_wdata = v; mode_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic det_resp(input logic [NP-1:0] m, input logic [NP-1:0] ok);
        int t = 0;
        while ((det_go & m) != m && t < 60) begin @(negedge clk); t++; end
        check("R2 detection request seen", int'((det_go & m) == m), 1);
        det_ok = ok; det_done = m;
        @(negedge clk);
        det_done = '0; det_ok = '0;
    endtask

    task automatic cls_resp(input logic [NP-1:0] m, input logic [2:0] code);
        int t = 0;
        while ((cls_go & m) != m && t < 60) begin @(negedge clk); t++; end
        check("R4 classification request seen", int'((cls_go & m) == m), 1);
        cls_in = {NP{code}}; cls_done = m;
        @(negedge clk);
        cls_done = '0;
    endtask

    task automatic count_low(input int p, output int n);
        n = 0;
        while (!det_go[p] && n < 1000) begin n++; @(negedge clk); end
    endtask

    // R1 R11: reset with pin low, then with pin high
    task automatic t_reset;
        do_reset(1'b0);
        check("R1 reset fields from low pin", int'(mode_q), 0);
        cyc(3);
        check("R11 shutdown ports idle", int'({det_go, cls_go, pwr_en}), 0);
        do_reset(1'b1);
        check("R1 reset fields from high pin", int'(mode_q), 8'hFF);
        check("R4 auto detects first", int'(det_go), 4'hF);
        check("R4 no class before detect", int'(cls_go), 0);
    endtask

    // R2 R9 R12 R10 R6 R7 R8 R11 in automatic mode
    task automatic t_auto;
        int n, t0, t1;
        logic chg0;
        det_resp(4'b0001, 4'b0000);
        count_low(0, n);
        check("R2 redetect after invalid", n, 1);
        det_resp(4'b0011, 4'b0011);
        check("R2 class after valid", int'(cls_go[1:0]), 3);
        cls_resp(4'b0011, 3'd4);
        check("R2 class code stored", int'(cls_code[2:0]), 4);
        t0 = -1; t1 = -1; chg0 = 1'b0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (pwr_en[0] && t0 < 0) begin t0 = i; chg0 = pwr_chg[0]; end
            if (pwr_en[1] && t1 < 0) t1 = i;
        end
        check("R2 power one cycle after class", t0, 1);
        check("R9 second port waits turn-on window", t1 - t0, TON + 1);
        check("R12 change pulse on rise", int'(chg0), 1);
        check("R12 pulse is single cycle", int'(pwr_chg[0]), 0);
        // fault timer busy blocks start
        fault_busy[2] = 1'b1;
        det_resp(4'b0100, 4'b0100);
        cls_resp(4'b0100, 3'd1);
        cyc(10);
        check("R9 busy fault timer blocks power", int'(pwr_en[2]), 0);
        fault_busy[2] = 1'b0;
        @(negedge clk);
        check("R9 start after fault timer clears", int'(pwr_en[2]), 1);
        // restart hold-off
        rsrt_en = 1'b1;
        ovc_fault[0] = 1'b1;
        @(negedge clk);
        ovc_fault[0] = 1'b0;
        check("R10 power drops after overcurrent", int'(pwr_en[0]), 0);
        count_low(0, n);
        check("R10 restart hold-off length", n, RST + 1);
        rsrt_en = 1'b0;
        ovc_fault[1] = 1'b1;
        @(negedge clk);
        ovc_fault[1] = 1'b0;
        count_low(1, n);
        check("R10 no hold-off when disabled", n, 1);
        // power-on ignored in auto
        pwr_on_cmd[0] = 1'b1;
        @(negedge clk);
        pwr_on_cmd[0] = 1'b0;
        @(negedge clk);
        check("R6 auto ignores power-on", int'({det_go[0], pwr_en[0]}), 2'b10);
        // midspan back-off
        midspan = 1'b1;
        det_resp(4'b1000, 4'b0000);
        count_low(3, n);
        check("R7 midspan back-off length", n, RTY + 1);
        midspan = 1'b0;
        // invalid class blocked
        poff_bad_class = 1'b1;
        det_resp(4'b1000, 4'b1000);
        cls_resp(4'b1000, 3'b111);
        check("R8 class 111 not powered", int'(pwr_en[3]), 0);
        @(negedge clk);
        check("R8 auto returns to detection", int'({det_go[3], pwr_en[3]}), 2'b10);
        poff_bad_class = 1'b0;
        // shutdown of a powered port
        set_mode(8'b11_00_11_11);
        check("R1 register write", int'(mode_q), 8'hCF);
        @(negedge clk);
        check("R11 shutdown removes power", int'(pwr_en[2]), 0);
        check("R12 change pulse on fall", int'(pwr_chg[2]), 1);
        cyc(5);
        check("R11 shutdown stays dark", int'({pwr_en[2], det_go[2], cls_go[2]}), 0);
    endtask

    // R3 R4 R6 R8 in semi-automatic mode
    task automatic t_semi;
        do_reset(1'b0);
        set_mode(8'hAA);
        det_en[0] = 1'b1; cls_en[0] = 1'b1;
        @(negedge clk);
        check("R4 detect before class", int'({det_go[0], cls_go[0]}), 2'b10);
        det_resp(4'b0001, 4'b0001);
        check("R3 class follows valid detect", int'(cls_go[0]), 1);
        cls_resp(4'b0001, 3'd2);
        cyc(8);
        check("R3 waits unpowered", int'({pwr_en[0], det_go[0], cls_go[0]}), 0);
        pwr_on_cmd[0] = 1'b1;
        @(negedge clk);
        pwr_on_cmd[0] = 1'b0;
        @(negedge clk);
        check("R3 power on command", int'(pwr_en[0]), 1);
        cls_en[1] = 1'b1;
        @(negedge clk);
        check("R4 class alone", int'({det_go[1], cls_go[1]}), 2'b01);
        poff_bad_class = 1'b1;
        cls_resp(4'b0010, 3'b111);
        check("R8 class code 111 stored", int'(cls_code[5:3]), 7);
        pwr_on_cmd[1] = 1'b1;
        @(negedge clk);
        pwr_on_cmd[1] = 1'b0;
        cyc(3);
        check("R8 power-on refused for class 111", int'(pwr_en[1]), 0);
        poff_bad_class = 1'b0;
        det_en[2] = 1'b1;
        @(negedge clk);
        check("R6 detection running", int'(det_go[2]), 1);
        pwr_on_cmd[2] = 1'b1;
        @(negedge clk);
        pwr_on_cmd[2] = 1'b0;
        check("R6 detection aborted", int'(det_go[2]), 0);
        @(negedge clk);
        check("R6 power after abort", int'(pwr_en[2]), 1);
    endtask

    // R5 manual pushbuttons
    task automatic t_manual;
        set_mode(8'b01_10_10_10);
        det_push[3] = 1'b1;
        @(negedge clk);
        det_push[3] = 1'b0;
        check("R5 push starts detection", int'(det_go[3]), 1);
        det_resp(4'b1000, 4'b1000);
        check("R5 one operation only", int'({det_go[3], cls_go[3]}), 0);
        cyc(4);
        check("R5 stays idle", int'({det_go[3], cls_go[3], pwr_en[3]}), 0);
        cls_push[3] = 1'b1;
        @(negedge clk);
        cls_push[3] = 1'b0;
        check("R5 push starts classification", int'(cls_go[3]), 1);
        cls_resp(4'b1000, 3'd0);
        check("R5 class ends idle", int'(cls_go[3]), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_auto();
        t_semi();
        t_manual();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule